// File: doc/BRIEF.md
# Vectored External Interrupt Controller

This block sits beside a processor core. It takes a set of level-sensitive interrupt request lines and picks a single active request. It presents that request to the core together with a handler address, the number of the shadow register set the core should switch to, and a priority level. A flag marks the request as non-maskable. Software programs the settings of each line through a small register port: a priority level, a register-set number, an enable bit and a non-maskable select. The core compares the presented level with its own state. It consumes the presentation with a valid/acknowledge handshake.

Each line has a key. A non-maskable line outranks every maskable line. Among maskable lines, the higher level wins. When keys are equal, the lowest line index wins. The handler address is a fixed vector base plus the line index times a fixed stride. Once a request is presented, it stays frozen until it is acknowledged. Before the acknowledge, only a request with a strictly higher key can replace it.

Top module: `eic_vectored`

## Requirements
- R1: After reset, `out_valid` is low and every line's configuration reads back as zero.
- R2: A write with `cfg_we` high stores `cfg_wdata` for line `cfg_addr`. `cfg_rdata` returns the stored word of the line addressed in the previous cycle, before any write in that cycle. The word layout is bits 5:0 level, bits 9:6 register set, bit 10 enable and bit 11 non-maskable. Addresses at or above the line count ignore writes and read zero.
- R3: A line is presented only while its request is high and it is either non-maskable, or enabled with a non-zero level. When no line qualifies, `out_valid` stays low.
- R4: A non-maskable line beats any maskable line. Among maskable lines, the higher level wins. Equal keys resolve to the lowest line index.
- R5: `out_addr` equals VEC_BASE + `out_idx` × VEC_STRIDE whenever `out_valid` is high.
- R6: The presentation carries the chosen line's register set. For a maskable line it also carries the line's level, with `out_nmi` low. For a non-maskable line, `out_nmi` is high and `out_lvl` is zero.
- R7: While `out_valid` is high and `out_ack` is low, all outputs hold. The only exception is a qualifying request with a strictly higher key, which replaces the presentation.
- R8: All outputs are registered. A request or acknowledge sampled at one rising edge takes effect on the outputs after that same edge.
- R9: An acknowledge frees the output stage. At that edge it loads the current winner again (which may be the same line if its request is still high), or drops `out_valid` if there is none.
- R10: The line count is a parameter. With the default of 40 lines, lines above index 31 are arbitrated and vectored like any others.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq | input | N_IRQ | Level-sensitive request lines |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | IDX_W | Line index for write and readback |
| cfg_wdata | input | CFG_W | Configuration word to store |
| cfg_rdata | output | CFG_W | Configuration word of the previously addressed line |
| out_valid | output | 1 | A request is being presented |
| out_ack | input | 1 | Core accepts the presented request |
| out_idx | output | IDX_W | Index of the presented line |
| out_addr | output | ADDR_W | Handler address |
| out_rset | output | RS_W | Register set to switch to |
| out_lvl | output | LVL_W | Level (zero for non-maskable) |
| out_nmi | output | 1 | Non-maskable flag |

## Verification
All presentation outputs are due one rising edge after the edge that samples a change on the request lines, in the configuration or on the acknowledge. Readback data is due one edge after the address. The bench drives inputs on the falling edge. A behavioural model updates at each rising edge from the same inputs, and the outputs are compared on the following falling edge, so each result is checked exactly in the cycle it is due. Hand-computed checks at chosen points cover ties, disabled and level-zero lines, preemption before acknowledge, and the lines above index 31.

// File: rtl/eic_pkg.sv
package eic_pkg;
  localparam int EIC_LVL_W = 6;
  localparam int EIC_RS_W  = 4;

  typedef struct packed {
    logic                 nmi;
    logic                 en;
    logic [EIC_RS_W-1:0]  rset;
    logic [EIC_LVL_W-1:0] lvl;
  } line_cfg_t;

  localparam int EIC_CFG_W = $bits(line_cfg_t);
endpackage

// File: rtl/eic_cfg_bank.sv
module eic_cfg_bank
  import eic_pkg::*;
#(
  parameter int N_IRQ = 40,
  parameter int IDX_W = 6
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [IDX_W-1:0]       addr,
  input  logic [EIC_CFG_W-1:0]   wdata,
  output logic [EIC_CFG_W-1:0]   rdata,
  output line_cfg_t [N_IRQ-1:0]  cfg
);
  line_cfg_t [N_IRQ-1:0] cfg_q;
  logic                  in_range;

  assign in_range = int'(addr) < N_IRQ;
  assign cfg      = cfg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q <= '0;
      rdata <= '0;
    end else begin
      rdata <= in_range ? cfg_q[addr] : '0;
      if (we && in_range) cfg_q[addr] <= line_cfg_t'(wdata);
    end
  end
endmodule

// File: rtl/eic_pick.sv
module eic_pick
  import eic_pkg::*;
#(
  parameter int N_IRQ = 40,
  parameter int IDX_W = 6
) (
  input  logic [N_IRQ-1:0]        irq,
  input  line_cfg_t [N_IRQ-1:0]   cfg,
  output logic                    found,
  output logic [IDX_W-1:0]        win_idx,
  output logic [EIC_LVL_W:0]      win_key,
  output logic [EIC_RS_W-1:0]     win_rset
);
  always_comb begin
    logic                elig;
    logic [EIC_LVL_W:0]  key;
    found   = 1'b0;
    win_idx = '0;
    win_key = '0;
    for (int i = 0; i < N_IRQ; i++) begin
      elig = irq[i] && (cfg[i].nmi || (cfg[i].en && cfg[i].lvl != '0));
      key  = cfg[i].nmi ? {1'b1, {EIC_LVL_W{1'b0}}} : {1'b0, cfg[i].lvl};
      if (elig && (!found || key > win_key)) begin
        found   = 1'b1;
        win_idx = IDX_W'(i);
        win_key = key;
      end
    end
  end

  assign win_rset = cfg[win_idx].rset;
endmodule

// File: rtl/eic_present.sv
module eic_present
  import eic_pkg::*;
#(
  parameter int                IDX_W      = 6,
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE   = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] VEC_STRIDE = 32'h0000_0020
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  found,
  input  logic [IDX_W-1:0]      win_idx,
  input  logic [EIC_LVL_W:0]    win_key,
  input  logic [EIC_RS_W-1:0]   win_rset,
  input  logic                  ack,
  output logic                  valid,
  output logic [IDX_W-1:0]      idx,
  output logic [EIC_LVL_W:0]    key,
  output logic [EIC_RS_W-1:0]   rset,
  output logic [ADDR_W-1:0]     addr
);
  logic take;

  // Load when free, when consumed, or when strictly outranked.
  assign take = !valid || ack || (found && win_key > key);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      idx   <= '0;
      key   <= '0;
      rset  <= '0;
      addr  <= '0;
    end else if (take) begin
      valid <= found;
      idx   <= win_idx;
      key   <= win_key;
      rset  <= win_rset;
      addr  <= VEC_BASE + ADDR_W'(win_idx) * VEC_STRIDE;
    end
  end
endmodule

// File: rtl/eic_vectored.sv
module eic_vectored
  import eic_pkg::*;
#(
  parameter int                N_IRQ      = 40,
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE   = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] VEC_STRIDE = 32'h0000_0020,
  localparam int               IDX_W      = (N_IRQ > 1) ? $clog2(N_IRQ) : 1,
  localparam int               CFG_W      = EIC_CFG_W,
  localparam int               LVL_W      = EIC_LVL_W,
  localparam int               RS_W       = EIC_RS_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [N_IRQ-1:0]   irq,
  input  logic               cfg_we,
  input  logic [IDX_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]   cfg_wdata,
  output logic [CFG_W-1:0]   cfg_rdata,
  output logic               out_valid,
  input  logic               out_ack,
  output logic [IDX_W-1:0]   out_idx,
  output logic [ADDR_W-1:0]  out_addr,
  output logic [RS_W-1:0]    out_rset,
  output logic [LVL_W-1:0]   out_lvl,
  output logic               out_nmi
);
  line_cfg_t [N_IRQ-1:0] cfg;
  logic                  found;
  logic [IDX_W-1:0]      win_idx;
  logic [LVL_W:0]        win_key;
  logic [RS_W-1:0]       win_rset;
  logic [LVL_W:0]        cur_key;

  eic_cfg_bank #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr),
    .wdata(cfg_wdata), .rdata(cfg_rdata), .cfg(cfg)
  );

  eic_pick #(.N_IRQ(N_IRQ), .IDX_W(IDX_W)) u_pick (
    .irq(irq), .cfg(cfg), .found(found), .win_idx(win_idx),
    .win_key(win_key), .win_rset(win_rset)
  );

  eic_present #(
    .IDX_W(IDX_W), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
  ) u_present (
    .clk(clk), .rst(rst), .found(found), .win_idx(win_idx), .win_key(win_key),
    .win_rset(win_rset), .ack(out_ack), .valid(out_valid), .idx(out_idx),
    .key(cur_key), .rset(out_rset), .addr(out_addr)
  );

  assign out_nmi = cur_key[LVL_W];
  assign out_lvl = cur_key[LVL_W-1:0];
endmodule

// File: rtl/eic_vectored_chk.sv
module eic_vectored_chk #(
  parameter int                N_IRQ      = 40,
  parameter int                ADDR_W     = 32,
  parameter logic [ADDR_W-1:0] VEC_BASE   = 32'h0000_1000,
  parameter logic [ADDR_W-1:0] VEC_STRIDE = 32'h0000_0020,
  parameter int                IDX_W      = 6,
  parameter int                RS_W       = 4,
  parameter int                LVL_W      = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              out_valid,
  input logic              out_ack,
  input logic [IDX_W-1:0]  out_idx,
  input logic [ADDR_W-1:0] out_addr,
  input logic [RS_W-1:0]   out_rset,
  input logic [LVL_W-1:0]  out_lvl,
  input logic              out_nmi
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !out_valid);

  // R6
  nmi_no_level_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_nmi) |-> (out_lvl == '0));

  // R3
  maskable_level_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_nmi) |-> (out_lvl != '0));

  // R5
  vector_addr_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_addr == VEC_BASE + ADDR_W'(out_idx) * VEC_STRIDE));

  // R7
  hold_valid_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ack) |=> out_valid);

  // R7
  hold_or_preempt_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ack) |=>
      ((out_idx == $past(out_idx) && $stable(out_rset) && $stable(out_nmi) && $stable(out_lvl))
       || ({out_nmi, out_lvl} > $past({out_nmi, out_lvl}))));
endmodule

bind eic_vectored eic_vectored_chk #(
  .N_IRQ(N_IRQ), .ADDR_W(ADDR_W), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE),
  .IDX_W(IDX_W), .RS_W(RS_W), .LVL_W(LVL_W)
) u_chk (
  .clk(clk), .rst(rst), .out_valid(out_valid), .out_ack(out_ack), .out_idx(out_idx),
  .out_addr(out_addr), .out_rset(out_rset), .out_lvl(out_lvl), .out_nmi(out_nmi)
);

// File: tb/tb_eic_vectored.sv
`timescale 1ns/1ps
module tb_eic_vectored;
  localparam int N     = 40;
  localparam int IW    = 6;
  localparam int BASE  = 32'h1000;
  localparam int STEP  = 32'h20;
  localparam int NMIK  = 1000;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [N-1:0]  irq = '0;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_addr = '0;
  logic [11:0]   cfg_wdata = '0;
  logic [11:0]   cfg_rdata;
  logic          out_valid;
  logic          out_ack = 1'b0;
  logic [IW-1:0] out_idx;
  logic [31:0]   out_addr;
  logic [3:0]    out_rset;
  logic [5:0]    out_lvl;
  logic          out_nmi;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  eic_vectored dut (
    .clk(clk), .rst(rst), .irq(irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .out_valid(out_valid),
    .out_ack(out_ack), .out_idx(out_idx), .out_addr(out_addr),
    .out_rset(out_rset), .out_lvl(out_lvl), .out_nmi(out_nmi)
  );

  // behavioural reference model
  int m_lvl[N], m_rs[N], m_en[N], m_nmi[N];
  bit mv = 0, mhold = 0, cmp_on = 0;
  int midx = 0, mkey = 0, mrs = 0, mrd = 0;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_rs[i] = 0; m_en[i] = 0; m_nmi[i] = 0; end
      mv = 0; mhold = 0; mrd = 0;
    end else begin
      bit f; int wi, wk, a;
      f = 0; wi = 0; wk = -1;
      for (int i = 0; i < N; i++) begin
        if (irq[i] && (m_nmi[i] != 0 || (m_en[i] != 0 && m_lvl[i] != 0))) begin
          int k;
          k = (m_nmi[i] != 0) ? NMIK : m_lvl[i];
          if (k > wk) begin f = 1; wi = i; wk = k; end
        end
      end
      mhold = mv && !out_ack && !(f && wk > mkey);
      if (!mhold) begin
        mv = f;
        if (f) begin midx = wi; mkey = wk; mrs = m_rs[wi]; end
      end
      a = int'(cfg_addr);
      mrd = (a < N) ? ((m_nmi[a] << 11) | (m_en[a] << 10) | (m_rs[a] << 6) | m_lvl[a]) : 0;
      if (cfg_we && a < N) begin
        m_lvl[a] = cfg_wdata[5:0]; m_rs[a] = cfg_wdata[9:6];
        m_en[a]  = cfg_wdata[10];  m_nmi[a] = cfg_wdata[11];
      end
    end
  end

  always @(negedge clk) begin
    if (cmp_on) begin
      checks++;
      if (out_valid !== mv) begin
        errors++; $display("FAIL R3 valid act=%0b exp=%0b", out_valid, mv);
      end else if (mv) begin
        if (out_idx !== midx[IW-1:0]) begin
          errors++; $display("FAIL %s idx act=%0d exp=%0d", mhold ? "R7" : "R4", out_idx, midx);
        end
        if (out_addr !== 32'(BASE + midx * STEP)) begin
          errors++; $display("FAIL R5 addr act=%h exp=%h", out_addr, BASE + midx * STEP);
        end
        if (out_rset !== mrs[3:0] || out_nmi !== (mkey == NMIK) ||
            out_lvl !== ((mkey == NMIK) ? 6'd0 : mkey[5:0])) begin
          errors++;
          $display("FAIL R6 rs/nmi/lvl act=%0d/%0b/%0d exp=%0d/%0b/%0d", out_rset, out_nmi,
                   out_lvl, mrs, mkey == NMIK, (mkey == NMIK) ? 0 : mkey);
        end
      end
      if (cfg_rdata !== mrd[11:0]) begin
        errors++; $display("FAIL R2 rdata act=%h exp=%h", cfg_rdata, mrd);
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(int line, int lvl, int rs, int en, int nmi);
    cfg_we = 1'b1; cfg_addr = IW'(line);
    cfg_wdata = 12'((nmi << 11) | (en << 10) | (rs << 6) | lvl);
    step();
    cfg_we = 1'b0;
  endtask

  task automatic expect_out(string tag, bit v, int idx, int lvl, bit nmi);
    checks++;
    if (out_valid !== v || (v && (out_idx !== idx[IW-1:0] || out_lvl !== lvl[5:0] || out_nmi !== nmi))) begin
      errors++;
      $display("FAIL %s act v=%0b idx=%0d lvl=%0d nmi=%0b exp v=%0b idx=%0d lvl=%0d nmi=%0b",
               tag, out_valid, out_idx, out_lvl, out_nmi, v, idx, lvl, nmi);
    end
  endtask

  task automatic expect_rd(string tag, int exp);
    checks++;
    if (cfg_rdata !== exp[11:0]) begin
      errors++; $display("FAIL %s rdata act=%h exp=%h", tag, cfg_rdata, exp);
    end
  endtask

  task automatic ack_pulse();
    out_ack = 1'b1; step(); out_ack = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog act=running exp=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    step(); step();
    rst = 1'b0;
    cmp_on = 1'b1;
    cfg_addr = IW'(9); step();
    expect_out("R1", 0, 0, 0, 0);
    expect_rd("R1", 0);

    wr(3, 5, 2, 1, 0);  wr(7, 5, 3, 1, 0);  wr(10, 9, 1, 1, 0);
    wr(12, 4, 0, 0, 0); wr(15, 0, 1, 1, 0); wr(20, 7, 6, 0, 1);
    wr(22, 0, 7, 0, 1); wr(37, 12, 5, 1, 0);
    wr(50, 3, 3, 1, 0);
    cfg_addr = IW'(10); step();
    expect_rd("R2", (1 << 10) | (1 << 6) | 9);
    cfg_addr = IW'(50); step();
    expect_rd("R2", 0);

    // R8: one edge from request to presentation
    irq[3] = 1'b1; step();
    expect_out("R8", 1, 3, 5, 0);
    // R9: ack with request dropped empties the stage
    irq = '0; ack_pulse();
    expect_out("R9", 0, 0, 0, 0);
    // R4 tie: lowest index
    irq[7] = 1'b1; irq[3] = 1'b1; step();
    expect_out("R4", 1, 3, 5, 0);
    irq = '0; ack_pulse(); step();
    // R3 disabled and level-zero lines are ignored
    irq[12] = 1'b1; irq[15] = 1'b1; step(); step();
    expect_out("R3", 0, 0, 0, 0);
    irq = '0;
    // R7 preemption by a higher level before ack
    irq[3] = 1'b1; step();
    irq[10] = 1'b1; step();
    expect_out("R7", 1, 10, 9, 0);
    irq[7] = 1'b1; step();
    expect_out("R7", 1, 10, 9, 0);
    // R6 non-maskable (disabled, level set) wins and shows level 0
    irq[20] = 1'b1; step();
    expect_out("R6", 1, 20, 0, 1);
    irq[22] = 1'b1; step();
    expect_out("R7", 1, 20, 0, 1);
    // R9 ack with request still high re-presents same line
    ack_pulse();
    expect_out("R9", 1, 20, 0, 1);
    irq[20] = 1'b0; ack_pulse();
    expect_out("R4", 1, 22, 0, 1);
    irq = '0; ack_pulse(); step();
    // R10 high line above index 31
    irq[37] = 1'b1; irq[3] = 1'b1; step();
    expect_out("R10", 1, 37, 12, 0);
    checks++;
    if (out_addr !== 32'h14A0) begin
      errors++; $display("FAIL R10 addr act=%h exp=%h", out_addr, 32'h14A0);
    end
    irq[37] = 1'b0; ack_pulse();
    expect_out("R4", 1, 3, 5, 0);
    // R2 reconfigure while presented: hold until ack, then new setting applies
    wr(3, 1, 9, 1, 0);
    expect_out("R7", 1, 3, 5, 0);
    ack_pulse();
    expect_out("R6", 1, 3, 1, 0);
    irq = '0; ack_pulse(); step();

    cmp_on = 1'b0;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule